// File: doc/BRIEF.md
# Two-Level Cell Header Address Compressor

This block turns the routing fields of a received ATM cell into the word address of its connection-table entry. The combined PHY+VPI field is reduced through a 16-bit VP mask: the header bits under the mask's ones are packed, in order, into a dense VP pointer. That pointer indexes a first-level table of 32-bit words placed at a configured VP base. The word read back carries a VC offset, which selects one second-level table. The VCI is packed through a VC mask into a VC pointer, and the final entry address is the VC base plus four times the sum of offset and pointer. When the VC tables sit back to back, each first-level entry holds the running total of the sizes of the tables that come before it.

Each lookup is one pass through a small state machine. The states are IDLE (waiting for a start), FETCH (holding a read request for the first-level word) and DONE (a one-cycle result). The transitions are: IDLE→FETCH on a start pulse, which latches both header fields; FETCH→FETCH while read-valid is low; FETCH→DONE on read-valid, which captures the offset and the result; and DONE→IDLE unconditionally. An optional check flags a cell as misinserted when a header bit outside its mask is set. The lookup still completes, but the address is then marked invalid.

Top module: `hac_hdr_compress`

## Requirements
- R1: The VP pointer holds the PHY+VPI bits found at the positions where the VP mask is 1, packed from bit 0 upward in ascending position order (mask 0x0237 with PHY+VPI 0x0011 gives pointer 0x09).
- R2: In the cycle after an accepted start, `rd_req` is high with `rd_addr` = VP base + 4 × VP pointer. Both signals stay unchanged until the cycle in which `rd_valid` is sampled high.
- R3: The VC offset is bits [15:0] of `rd_data`, and bits [31:16] have no effect. `vc_addr` = VC base + 4 × (offset + VC pointer), where the VC pointer packs the VCI through the VC mask in the same way as R1.
- R4: `done` is high for exactly the one cycle that follows the cycle in which `rd_valid` was sampled high during FETCH.
- R5: With `cfg_chk_en` = 1, any 1 in PHY+VPI where the VP mask is 0, or in the VCI where the VC mask is 0, makes `misinserted` = 1 and `vc_addr_valid` = 0 during `done`.
- R6: With `cfg_chk_en` = 0, bits outside the masks are ignored: `misinserted` = 0 and `vc_addr_valid` = 1 during `done`.
- R7: `busy` is high from the cycle after an accepted start through the `done` cycle. A `cell_start` seen while busy is ignored and does not change the lookup in progress.
- R8: After reset, `busy`, `rd_req`, `done`, `vc_addr_valid` and `misinserted` are 0.
- R9: An all-zero mask gives pointer 0, so the read goes to the VP base itself. An all-ones mask passes the field through unchanged as the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vp_base | input | 32 | Byte address of the first-level table |
| cfg_vp_mask | input | 16 | Selects the PHY+VPI bits that form the VP pointer |
| cfg_vc_base | input | 32 | Byte address of the VC table region |
| cfg_vc_mask | input | 16 | Selects the VCI bits that form the VC pointer |
| cfg_chk_en | input | 1 | Enables the unallocated-bit check |
| cell_start | input | 1 | Start pulse; header fields are latched when accepted |
| cell_phyvpi | input | 16 | Combined PHY+VPI field of the cell |
| cell_vci | input | 16 | VCI field of the cell |
| busy | output | 1 | A lookup is in progress |
| rd_req | output | 1 | Read request for the first-level word |
| rd_addr | output | 32 | Byte address of the first-level entry |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 32 | First-level entry word; bits [15:0] hold the VC offset |
| done | output | 1 | One-cycle pulse when the result is presented |
| vc_addr | output | 32 | Byte address of the VC-level entry |
| vc_addr_valid | output | 1 | High during done when the cell is not misinserted |
| misinserted | output | 1 | High during done when a stray header bit was found |

## Verification
The assertions check every cycle that `done` is a single-cycle pulse that follows read-valid, that the request and its address hold steady while the read is pending, that `busy` cannot drop before `done`, that the valid and misinserted outputs are exclusive and appear only with `done`, and that the bit gather keeps exactly the masked ones. The bench's reference model compares the outputs on every clock, so the exact pointer values, the final addresses, the fact that the upper word bits are ignored, and the behaviour of a start pulse during a lookup are shown only by its scenarios. These scenarios use a range of masks, read latencies and check settings.

// File: rtl/hac_pkg.sv
package hac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } hac_state_e;

endpackage

// File: rtl/hac_bit_gather.sv
// Packs the data bits that sit under mask ones into a dense value, lowest
// position first. Each output bit is an OR over all inputs whose prefix count
// of mask ones equals that output index, so no priority chain is needed.
module hac_bit_gather #(
    parameter int W = 16
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] packed_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] pfx [W+1];

    assign pfx[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_pfx
        assign pfx[i+1] = pfx[i] + CNT_W'(mask_i[i]);
    end

    for (genvar j = 0; j < W; j++) begin : g_out
        logic [W-1:0] hit;
        for (genvar i = 0; i < W; i++) begin : g_hit
            assign hit[i] = mask_i[i] & data_i[i] & (pfx[i] == CNT_W'(j));
        end
        assign packed_o[j] = |hit;
    end

    always_comb begin
        if (!$isunknown({data_i, mask_i})) begin
            assert_gather_keeps_ones_R1:
                assert ($countones(packed_o) == $countones(data_i & mask_i));
            assert_gather_dense_R1:
                assert ((packed_o >> pfx[W]) == '0);
        end
    end

endmodule

// File: rtl/hac_unalloc_check.sv
// Reports a header bit that is set outside its allocation mask.
module hac_unalloc_check #(
    parameter int VP_W = 16,
    parameter int VC_W = 16
) (
    input  logic            en_i,
    input  logic [VP_W-1:0] vp_field_i,
    input  logic [VP_W-1:0] vp_mask_i,
    input  logic [VC_W-1:0] vc_field_i,
    input  logic [VC_W-1:0] vc_mask_i,
    output logic            stray_o
);
    logic vp_stray;
    logic vc_stray;

    assign vp_stray = |(vp_field_i & ~vp_mask_i);
    assign vc_stray = |(vc_field_i & ~vc_mask_i);
    assign stray_o  = en_i & (vp_stray | vc_stray);

endmodule

// File: rtl/hac_addr_gen.sv
// Word-entry addressing: base plus four bytes per index.
module hac_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 17
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  index_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int BYTE_SH = 2;

    assign addr_o = base_i + (ADDR_W'(index_i) << BYTE_SH);

endmodule

// File: rtl/hac_hdr_compress.sv
module hac_hdr_compress
    import hac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VP_W   = 16,
    parameter int VC_W   = 16,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_vp_base,
    input  logic [VP_W-1:0]   cfg_vp_mask,
    input  logic [ADDR_W-1:0] cfg_vc_base,
    input  logic [VC_W-1:0]   cfg_vc_mask,
    input  logic              cfg_chk_en,
    input  logic              cell_start,
    input  logic [VP_W-1:0]   cell_phyvpi,
    input  logic [VC_W-1:0]   cell_vci,
    output logic              busy,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] vc_addr,
    output logic              vc_addr_valid,
    output logic              misinserted
);
    localparam int MAX_W  = (VC_W > OFF_W) ? VC_W : OFF_W;
    localparam int VCIX_W = MAX_W + 1;

    hac_state_e state_q, state_d;

    logic [VP_W-1:0]   phyvpi_q;
    logic [VC_W-1:0]   vci_q;
    logic [VP_W-1:0]   vp_ptr;
    logic [VC_W-1:0]   vc_ptr;
    logic [OFF_W-1:0]  vc_off;
    logic [VCIX_W-1:0] vc_index;
    logic [ADDR_W-1:0] vc_addr_d;
    logic [ADDR_W-1:0] vc_addr_q;
    logic              stray;
    logic              stray_q;
    logic              accept;
    logic              capture;

    // ---------------- datapath ----------------
    hac_bit_gather #(.W(VP_W)) u_vp_gather (
        .data_i   (phyvpi_q),
        .mask_i   (cfg_vp_mask),
        .packed_o (vp_ptr)
    );

    hac_bit_gather #(.W(VC_W)) u_vc_gather (
        .data_i   (vci_q),
        .mask_i   (cfg_vc_mask),
        .packed_o (vc_ptr)
    );

    hac_unalloc_check #(.VP_W(VP_W), .VC_W(VC_W)) u_chk (
        .en_i       (cfg_chk_en),
        .vp_field_i (phyvpi_q),
        .vp_mask_i  (cfg_vp_mask),
        .vc_field_i (vci_q),
        .vc_mask_i  (cfg_vc_mask),
        .stray_o    (stray)
    );

    hac_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(VP_W)) u_vp_addr (
        .base_i  (cfg_vp_base),
        .index_i (vp_ptr),
        .addr_o  (rd_addr)
    );

    assign vc_off   = rd_data[OFF_W-1:0];
    assign vc_index = VCIX_W'(vc_off) + VCIX_W'(vc_ptr);

    hac_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(VCIX_W)) u_vc_addr (
        .base_i  (cfg_vc_base),
        .index_i (vc_index),
        .addr_o  (vc_addr_d)
    );

    assign accept  = (state_q == ST_IDLE) && cell_start;
    assign capture = (state_q == ST_FETCH) && rd_valid;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cell_start) state_d = ST_FETCH;
            ST_FETCH: if (rd_valid)   state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- captured values ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phyvpi_q  <= '0;
            vci_q     <= '0;
            vc_addr_q <= '0;
            stray_q   <= 1'b0;
        end else begin
            if (accept) begin
                phyvpi_q <= cell_phyvpi;
                vci_q    <= cell_vci;
            end
            if (capture) begin
                vc_addr_q <= vc_addr_d;
                stray_q   <= stray;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy          = 1'b0;
        rd_req        = 1'b0;
        done          = 1'b0;
        vc_addr_valid = 1'b0;
        misinserted   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                busy   = 1'b1;
                rd_req = 1'b1;
            end
            ST_DONE: begin
                busy          = 1'b1;
                done          = 1'b1;
                vc_addr_valid = ~stray_q;
                misinserted   = stray_q;
            end
            default: ;
        endcase
    end

    assign vc_addr = vc_addr_q;

    // ---------------- assertions ----------------
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    assert_done_after_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> done);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (misinserted || vc_addr_valid) |-> (done && !(misinserted && vc_addr_valid)));

    assert_check_off_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_chk_en) |-> vc_addr_valid);

    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_start_needs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !$past(rd_req)) |-> !$past(busy));

endmodule

// File: tb/hac_hdr_compress_tb_top.sv
module hac_hdr_compress_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_vp_base = '0;
    logic [15:0] cfg_vp_mask = '0;
    logic [31:0] cfg_vc_base = '0;
    logic [15:0] cfg_vc_mask = '0;
    logic        cfg_chk_en = 1'b0;
    logic        cell_start = 1'b0;
    logic [15:0] cell_phyvpi = '0;
    logic [15:0] cell_vci = '0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, rd_req, done, vc_addr_valid, misinserted;
    logic [31:0] rd_addr, vc_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hac_hdr_compress dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_vp_base(cfg_vp_base), .cfg_vp_mask(cfg_vp_mask),
        .cfg_vc_base(cfg_vc_base), .cfg_vc_mask(cfg_vc_mask),
        .cfg_chk_en(cfg_chk_en),
        .cell_start(cell_start), .cell_phyvpi(cell_phyvpi), .cell_vci(cell_vci),
        .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .vc_addr(vc_addr),
        .vc_addr_valid(vc_addr_valid), .misinserted(misinserted)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] squeeze(input logic [15:0] d, input logic [15:0] m);
        logic [15:0] r = '0;
        int k = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                r = r | (16'(d[i]) << k);
                k++;
            end
        end
        return r;
    endfunction

    // ---------------- reference model ----------------
    int          m_st = 0;          // 0 idle, 1 waiting for read, 2 result
    logic [15:0] m_phy = '0, m_vci = '0;
    logic [31:0] m_vc_addr = '0;
    bit          m_bad = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (cell_start) begin
                       m_phy = cell_phyvpi;
                       m_vci = cell_vci;
                       m_st = 1;
                   end
                1: if (rd_valid) begin
                       m_vc_addr = cfg_vc_base +
                           ((32'(rd_data[15:0]) + 32'(squeeze(m_vci, cfg_vc_mask))) * 4);
                       m_bad = cfg_chk_en &&
                           (((m_phy & ~cfg_vp_mask) != 0) || ((m_vci & ~cfg_vc_mask) != 0));
                       m_st = 2;
                   end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check(busy == (m_st != 0), "R7 busy", 32'(busy), 32'(m_st != 0));
            check(rd_req == (m_st == 1), "R2 rd_req", 32'(rd_req), 32'(m_st == 1));
            check(done == (m_st == 2), "R4 done", 32'(done), 32'(m_st == 2));
            if (m_st == 1)
                check(rd_addr == cfg_vp_base + 32'(squeeze(m_phy, cfg_vp_mask)) * 4,
                      "R1 rd_addr", rd_addr, cfg_vp_base + 32'(squeeze(m_phy, cfg_vp_mask)) * 4);
            if (m_st == 2) begin
                check(vc_addr == m_vc_addr, "R3 vc_addr", vc_addr, m_vc_addr);
                check(misinserted == m_bad, "R5 misinserted", 32'(misinserted), 32'(m_bad));
                check(vc_addr_valid == !m_bad, "R6 vc_addr_valid", 32'(vc_addr_valid), 32'(!m_bad));
            end else begin
                check(!misinserted && !vc_addr_valid, "R5 flags outside done",
                      {30'd0, misinserted, vc_addr_valid}, 32'd0);
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [31:0] cap_rd_addr, cap_vc_addr;
    logic        cap_valid, cap_mis, cap_done;

    task automatic run_cell(input logic [15:0] phy, input logic [15:0] vci,
                            input int lat, input logic [31:0] word, input bit poke);
        @(negedge clk);
        cell_phyvpi = phy;
        cell_vci    = vci;
        cell_start  = 1'b1;
        @(negedge clk);
        cell_start  = poke;
        cell_phyvpi = ~phy;
        cell_vci    = ~vci;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            cell_start = 1'b0;
        end
        cell_start  = 1'b0;
        cap_rd_addr = rd_addr;
        rd_valid    = 1'b1;
        rd_data     = word;
        @(negedge clk);
        rd_valid    = 1'b0;
        rd_data     = 32'hDEAD_BEEF;
        #1;
        cap_done    = done;
        cap_vc_addr = vc_addr;
        cap_valid   = vc_addr_valid;
        cap_mis     = misinserted;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !rd_req && !done && !vc_addr_valid && !misinserted, "R8 reset outputs",
              {27'd0, busy, rd_req, done, vc_addr_valid, misinserted}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy && !rd_req && !done, "R8 idle after reset",
              {29'd0, busy, rd_req, done}, 32'd0);

        // worked example, upper word bits must not matter
        cfg_vp_base = 32'h0024_0000;
        cfg_vp_mask = 16'h0237;
        cfg_vc_base = 32'h0010_0000;
        cfg_vc_mask = 16'h03FF;
        cfg_chk_en  = 1'b1;
        run_cell(16'h0011, 16'h0005, 2, 32'hABCD_0048, 1'b0);
        check(cap_rd_addr == 32'h0024_0024, "R1 R2 example address", cap_rd_addr, 32'h0024_0024);
        check(cap_vc_addr == 32'h0010_0134, "R3 offset 72 plus 5", cap_vc_addr, 32'h0010_0134);
        check(cap_done && cap_valid && !cap_mis, "R4 result presented",
              {29'd0, cap_done, cap_valid, cap_mis}, 32'h6);

        // stray VP bit, check enabled
        run_cell(16'h0811, 16'h0005, 0, 32'h0000_0068, 1'b0);
        check(cap_mis && !cap_valid, "R5 stray vp bit", {30'd0, cap_mis, cap_valid}, 32'h2);
        // stray VCI bit
        run_cell(16'h0011, 16'h8005, 1, 32'h0000_0068, 1'b0);
        check(cap_mis && !cap_valid, "R5 stray vci bit", {30'd0, cap_mis, cap_valid}, 32'h2);

        // check disabled
        cfg_chk_en = 1'b0;
        run_cell(16'hF811, 16'h8005, 1, 32'h0000_0008, 1'b0);
        check(!cap_mis && cap_valid, "R6 stray ignored", {30'd0, cap_mis, cap_valid}, 32'h1);
        check(cap_vc_addr == 32'h0010_0034, "R6 address from masked bits", cap_vc_addr, 32'h0010_0034);

        // start while busy is ignored
        run_cell(16'h0001, 16'h0002, 3, 32'h0000_0020, 1'b1);
        check(cap_rd_addr == 32'h0024_0004, "R7 first cell kept", cap_rd_addr, 32'h0024_0004);
        check(cap_vc_addr == 32'h0010_0088, "R7 vc result kept", cap_vc_addr, 32'h0010_0088);
        #1;
        check(!busy, "R7 idle after poke", 32'(busy), 32'd0);

        // mask corners
        cfg_vp_mask = 16'h0000;
        cfg_chk_en  = 1'b0;
        run_cell(16'hBEEF, 16'h0000, 0, 32'h0, 1'b0);
        check(cap_rd_addr == 32'h0024_0000, "R9 empty mask", cap_rd_addr, 32'h0024_0000);
        cfg_vp_mask = 16'hFFFF;
        run_cell(16'h1234, 16'h0000, 0, 32'h0, 1'b0);
        check(cap_rd_addr == 32'h0024_48D0, "R9 full mask", cap_rd_addr, 32'h0024_48D0);

        // varied traffic checked by the model
        for (int n = 0; n < 40; n++) begin
            cfg_vp_mask = 16'($urandom);
            cfg_vc_mask = 16'($urandom);
            cfg_chk_en  = 1'($urandom);
            cfg_vp_base = $urandom & 32'hFFFF_FFF0;
            cfg_vc_base = $urandom & 32'hFFFF_FFF0;
            run_cell(16'($urandom) & (cfg_vp_mask | 16'($urandom)),
                     16'($urandom) & (cfg_vc_mask | 16'($urandom)),
                     int'($urandom % 5), $urandom, 1'($urandom));
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule